// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM

This block is a behavioural, synthesizable model of a small synchronous static RAM. It is meant to stand in for an external burst memory in a larger design. It stores 36-bit words built from four 9-bit lanes, and each lane holds eight data bits and one parity bit. All address, control and write-data inputs are captured on the rising clock edge. Writes are then completed inside the block with no external strobe. Read data passes an address/control register and then an output register before it is driven.

A load cycle (`load_n` low) samples the three chip enables. It either starts an access at `addr` or deselects the device. Later advance cycles (`adv_n` low) step a two-bit burst counter through the low address bits, in linear or interleaved order. Each access cycle is a read or a write. Which one depends on the global-write input, the byte-write input and the per-lane strobes in that cycle. The output drive is gated combinationally by an output enable and by a sleep input. Sleep also blocks accesses but keeps the stored contents.

Top module: `sync_burst_sram`

## Requirements
- R1: While `rst_n` is low and after its release with no access, `rdata_oe` is 0.
- R2: A read access sampled at clock edge k drives the stored word on `rdata` with `rdata_oe` = 1 from edge k+1 until edge k+2, provided `out_en_n` is 0 and `sleep` is 0.
- R3: With `wr_all_n` = 1 and `wr_byte_n` = 0, only lane i is written for each `lane_sel_n[i]` = 0. Lane i is `wdata[9i+8:9i]`, and bit 9i+8 is its parity bit, which is stored and returned like the other bits. With `wr_byte_n` = 1 the access is a read.
- R4: With `wr_all_n` = 0, all four lanes are written whatever `wr_byte_n` and `lane_sel_n` are.
- R5: The chip enables are sampled only on load cycles. The device is selected only when `en_a_n` = 0, `en_b` = 1 and `en_c_n` = 0. A load with any other combination writes nothing.
- R6: A load cycle with the device unselected, registered at edge k, leaves `rdata_oe` at 0 after edge k+1.
- R7: `out_en_n` = 1 forces `rdata_oe` to 0 at once, with no clock edge. Returning it to 0 restores the drive of a pending read.
- R8: While `sleep` = 1, `rdata_oe` is 0, no access is started and no write completes. Contents are retained, and a load on the first edge after release works normally.
- R9: With `order_lin` = 1, the n-th advance after a load at base address b accesses the low two address bits (b + n) mod 4, and the upper bits stay those of b.
- R10: With `order_lin` = 0, the n-th advance accesses low bits b XOR (n mod 4).
- R11: A cycle with `load_n` = 1 and `adv_n` = 1 performs no access, so `rdata_oe` is 0 after the following edge. The burst position is kept.
- R12: An advance with no burst active (after reset, a deselect or sleep) performs no access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of the control state |
| addr | input | ADDR_W | Word address sampled on load cycles |
| load_n | input | 1 | Active-low load: sample enables and start an access at `addr` |
| adv_n | input | 1 | Active-low advance to the next burst address |
| order_lin | input | 1 | Burst order: 1 linear, 0 interleaved |
| en_a_n | input | 1 | Active-low chip enable |
| en_b | input | 1 | Active-high chip enable |
| en_c_n | input | 1 | Active-low chip enable |
| wr_all_n | input | 1 | Active-low write of all lanes |
| wr_byte_n | input | 1 | Active-low byte-write mode |
| lane_sel_n | input | LANES | Active-low per-lane write strobes |
| wdata | input | LANES*(LANE_DATA_W+1) | Write data, lane i in bits 9i+8:9i |
| out_en_n | input | 1 | Asynchronous active-low output enable |
| sleep | input | 1 | Low-power request: blocks accesses and output drive |
| rdata | output | LANES*(LANE_DATA_W+1) | Read data |
| rdata_oe | output | 1 | Read data drive enable (0 = high impedance) |

## Verification
The clocked properties expect every control input to hold a known level at each rising edge once reset is released. They also expect `out_en_n` and `sleep` to be the only inputs that reach `rdata_oe` without passing a register. The read-latency property further expects a read load to be followed by an edge at which `sleep` is low. The stimulus meets all of this. It changes inputs only at the falling edge, draws every control bit from a seeded generator as a definite 0 or 1, and toggles `out_en_n` between edges only in the asynchronous-enable cases.

// File: rtl/ssram_pkg.sv
package ssram_pkg;

   // Burst address order: chosen by an input pin or fixed at build time.
   typedef enum logic [1:0] {
      ORDER_BY_PIN     = 2'd0,
      ORDER_LINEAR     = 2'd1,
      ORDER_INTERLEAVE = 2'd2
   } burst_order_e;

endpackage

// File: rtl/ssram_burst_ctr.sv
module ssram_burst_ctr
   import ssram_pkg::*;
#(
   parameter int           ADDR_W  = 6,
   parameter int           BURST_W = 2,
   parameter burst_order_e ORDER   = ORDER_BY_PIN
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              halt,
   input  logic              load_sel,
   input  logic              load_desel,
   input  logic              advance,
   input  logic              order_lin,
   input  logic [ADDR_W-1:0] addr,
   output logic              acc_go,
   output logic [ADDR_W-1:0] acc_addr
);

   localparam int HI_W = ADDR_W - BURST_W;

   logic [ADDR_W-1:0]  base_q;
   logic [BURST_W-1:0] step_q;
   logic [BURST_W-1:0] step_nxt;
   logic [BURST_W-1:0] lin_off;
   logic [BURST_W-1:0] ilv_off;
   logic [BURST_W-1:0] off;
   logic [HI_W-1:0]    base_hi;
   logic               active_q;
   logic               use_lin;

   assign step_nxt = step_q + BURST_W'(1);
   assign lin_off  = base_q[BURST_W-1:0] + step_nxt;
   assign ilv_off  = base_q[BURST_W-1:0] ^ step_nxt;
   assign use_lin  = (ORDER == ORDER_LINEAR) || ((ORDER == ORDER_BY_PIN) && order_lin);
   assign off      = use_lin ? lin_off : ilv_off;
   assign base_hi  = base_q[ADDR_W-1:BURST_W];

   assign acc_go   = !halt && (load_sel || (advance && active_q));
   assign acc_addr = load_sel ? addr : {base_hi, off};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         base_q   <= '0;
         step_q   <= '0;
      end else if (halt) begin
         active_q <= 1'b0;
      end else if (load_sel) begin
         active_q <= 1'b1;
         base_q   <= addr;
         step_q   <= '0;
      end else if (load_desel) begin
         active_q <= 1'b0;
      end else if (advance && active_q) begin
         step_q   <= step_nxt;
      end
   end

endmodule

// File: rtl/ssram_ctl_reg.sv
module ssram_ctl_reg #(
   parameter int ADDR_W = 6,
   parameter int LANES  = 4,
   parameter int LANE_W = 9
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    acc_go,
   input  logic [ADDR_W-1:0]       acc_addr,
   input  logic                    wr_all_n,
   input  logic                    wr_byte_n,
   input  logic [LANES-1:0]        lane_sel_n,
   input  logic [LANES*LANE_W-1:0] wdata,
   output logic                    s1_valid,
   output logic                    s1_write,
   output logic [ADDR_W-1:0]       s1_addr,
   output logic [LANES-1:0]        s1_lanes,
   output logic [LANES*LANE_W-1:0] s1_wdata
);

   logic [LANES-1:0] lane_we;

   for (genvar i = 0; i < LANES; i++) begin : g_lane_dec
      assign lane_we[i] = !wr_all_n || (!wr_byte_n && !lane_sel_n[i]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_valid <= 1'b0;
         s1_addr  <= '0;
         s1_lanes <= '0;
         s1_wdata <= '0;
      end else begin
         s1_valid <= acc_go;
         if (acc_go) begin
            s1_addr  <= acc_addr;
            s1_lanes <= lane_we;
            s1_wdata <= wdata;
         end
      end
   end

   assign s1_write = |s1_lanes;

endmodule

// File: rtl/ssram_array.sv
module ssram_array #(
   parameter int ADDR_W = 6,
   parameter int LANES  = 4,
   parameter int LANE_W = 9
) (
   input  logic                    clk,
   input  logic [LANES-1:0]        we,
   input  logic [ADDR_W-1:0]       addr,
   input  logic [LANES*LANE_W-1:0] wdata,
   output logic [LANES*LANE_W-1:0] rdata
);

   localparam int DEPTH = 1 << ADDR_W;

   for (genvar i = 0; i < LANES; i++) begin : g_lane_mem
      logic [LANE_W-1:0] mem [DEPTH];

      always_ff @(posedge clk) begin
         if (we[i]) begin
            mem[addr] <= wdata[i*LANE_W +: LANE_W];
         end
      end

      assign rdata[i*LANE_W +: LANE_W] = mem[addr];
   end

endmodule

// File: rtl/ssram_out_stage.sv
module ssram_out_stage #(
   parameter int WORD_W = 36
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              s1_valid,
   input  logic              s1_write,
   input  logic              sleep,
   input  logic              out_en_n,
   input  logic [WORD_W-1:0] arr_rdata,
   output logic [WORD_W-1:0] rdata,
   output logic              rdata_oe
);

   logic out_valid_q;
   logic capture;

   assign capture = s1_valid && !s1_write && !sleep;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid_q <= 1'b0;
         rdata       <= '0;
      end else begin
         out_valid_q <= capture;
         if (capture) begin
            rdata <= arr_rdata;
         end
      end
   end

   assign rdata_oe = out_valid_q && !out_en_n && !sleep;

endmodule

// File: rtl/sync_burst_sram.sv
module sync_burst_sram
   import ssram_pkg::*;
#(
   parameter int           ADDR_W      = 6,
   parameter int           LANES       = 4,
   parameter int           LANE_DATA_W = 8,
   parameter int           BURST_W     = 2,
   parameter burst_order_e ORDER       = ORDER_BY_PIN
) (
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic [ADDR_W-1:0]                    addr,
   input  logic                                 load_n,
   input  logic                                 adv_n,
   input  logic                                 order_lin,
   input  logic                                 en_a_n,
   input  logic                                 en_b,
   input  logic                                 en_c_n,
   input  logic                                 wr_all_n,
   input  logic                                 wr_byte_n,
   input  logic [LANES-1:0]                     lane_sel_n,
   input  logic [LANES*(LANE_DATA_W+1)-1:0]     wdata,
   input  logic                                 out_en_n,
   input  logic                                 sleep,
   output logic [LANES*(LANE_DATA_W+1)-1:0]     rdata,
   output logic                                 rdata_oe
);

   localparam int LANE_W = LANE_DATA_W + 1;
   localparam int WORD_W = LANES * LANE_W;

   if (ADDR_W <= BURST_W) begin : g_bad_addr
      $error("ADDR_W must exceed BURST_W");
   end
   if (BURST_W < 1) begin : g_bad_burst
      $error("BURST_W must be at least 1");
   end
   if (LANES < 1 || LANE_DATA_W < 1) begin : g_bad_lane
      $error("LANES and LANE_DATA_W must be positive");
   end

   logic              selected;
   logic              load_sel;
   logic              load_desel;
   logic              advance;
   logic              acc_go;
   logic [ADDR_W-1:0] acc_addr;
   logic              s1_valid;
   logic              s1_write;
   logic [ADDR_W-1:0] s1_addr;
   logic [LANES-1:0]  s1_lanes;
   logic [WORD_W-1:0] s1_wdata;
   logic [LANES-1:0]  arr_we;
   logic [WORD_W-1:0] arr_rdata;

   assign selected   = !en_a_n && en_b && !en_c_n;
   assign load_sel   = !load_n && selected;
   assign load_desel = !load_n && !selected;
   assign advance    = load_n && !adv_n;
   assign arr_we     = s1_lanes & {LANES{s1_valid && !sleep}};

   ssram_burst_ctr #(
      .ADDR_W  (ADDR_W),
      .BURST_W (BURST_W),
      .ORDER   (ORDER)
   ) u_burst (
      .clk        (clk),
      .rst_n      (rst_n),
      .halt       (sleep),
      .load_sel   (load_sel),
      .load_desel (load_desel),
      .advance    (advance),
      .order_lin  (order_lin),
      .addr       (addr),
      .acc_go     (acc_go),
      .acc_addr   (acc_addr)
   );

   ssram_ctl_reg #(
      .ADDR_W (ADDR_W),
      .LANES  (LANES),
      .LANE_W (LANE_W)
   ) u_ctl (
      .clk        (clk),
      .rst_n      (rst_n),
      .acc_go     (acc_go),
      .acc_addr   (acc_addr),
      .wr_all_n   (wr_all_n),
      .wr_byte_n  (wr_byte_n),
      .lane_sel_n (lane_sel_n),
      .wdata      (wdata),
      .s1_valid   (s1_valid),
      .s1_write   (s1_write),
      .s1_addr    (s1_addr),
      .s1_lanes   (s1_lanes),
      .s1_wdata   (s1_wdata)
   );

   ssram_array #(
      .ADDR_W (ADDR_W),
      .LANES  (LANES),
      .LANE_W (LANE_W)
   ) u_array (
      .clk   (clk),
      .we    (arr_we),
      .addr  (s1_addr),
      .wdata (s1_wdata),
      .rdata (arr_rdata)
   );

   ssram_out_stage #(
      .WORD_W (WORD_W)
   ) u_out (
      .clk       (clk),
      .rst_n     (rst_n),
      .s1_valid  (s1_valid),
      .s1_write  (s1_write),
      .sleep     (sleep),
      .out_en_n  (out_en_n),
      .arr_rdata (arr_rdata),
      .rdata     (rdata),
      .rdata_oe  (rdata_oe)
   );

endmodule

// File: rtl/sync_burst_sram_chk.sv
module sync_burst_sram_chk #(
   parameter int LANES = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             load_n,
   input logic             adv_n,
   input logic             en_a_n,
   input logic             en_b,
   input logic             en_c_n,
   input logic             wr_all_n,
   input logic             wr_byte_n,
   input logic [LANES-1:0] lane_sel_n,
   input logic             out_en_n,
   input logic             sleep,
   input logic             rdata_oe
);

   logic sel;
   logic read_load;

   assign sel       = !en_a_n && en_b && !en_c_n;
   assign read_load = !load_n && sel && !sleep && wr_all_n && (wr_byte_n || (&lane_sel_n));

   AST_READ_TWO_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
      read_load ##1 !sleep |=> (rdata_oe || out_en_n || sleep)); // R2

   AST_DESELECT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_n && !sel) |=> ##1 !rdata_oe); // R6

   AST_OE_ASYNC: assert property (@(posedge clk) disable iff (!rst_n)
      out_en_n |-> !rdata_oe); // R7

   AST_SLEEP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      sleep |-> !rdata_oe); // R8

   AST_IDLE_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
      (load_n && adv_n) |=> ##1 !rdata_oe); // R11

endmodule

bind sync_burst_sram sync_burst_sram_chk #(.LANES(LANES)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .load_n     (load_n),
   .adv_n      (adv_n),
   .en_a_n     (en_a_n),
   .en_b       (en_b),
   .en_c_n     (en_c_n),
   .wr_all_n   (wr_all_n),
   .wr_byte_n  (wr_byte_n),
   .lane_sel_n (lane_sel_n),
   .out_en_n   (out_en_n),
   .sleep      (sleep),
   .rdata_oe   (rdata_oe)
);

// File: tb/sync_burst_sram_test.sv
module sync_burst_sram_test;

   localparam int AW = 6;
   localparam int WW = 36;
   localparam int NW = 1 << AW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] addr = '0;
   logic          load_n = 1'b1, adv_n = 1'b1, order_lin = 1'b1;
   logic          en_a_n = 1'b0, en_b = 1'b1, en_c_n = 1'b0;
   logic          wr_all_n = 1'b1, wr_byte_n = 1'b1;
   logic [3:0]    lane_sel_n = 4'hF;
   logic [WW-1:0] wdata = '0;
   logic          out_en_n = 1'b0, sleep = 1'b0;
   logic [WW-1:0] rdata;
   logic          rdata_oe;

   always #2 clk = ~clk;

   sync_burst_sram uut (
      .clk(clk), .rst_n(rst_n), .addr(addr), .load_n(load_n), .adv_n(adv_n),
      .order_lin(order_lin), .en_a_n(en_a_n), .en_b(en_b), .en_c_n(en_c_n),
      .wr_all_n(wr_all_n), .wr_byte_n(wr_byte_n), .lane_sel_n(lane_sel_n),
      .wdata(wdata), .out_en_n(out_en_n), .sleep(sleep),
      .rdata(rdata), .rdata_oe(rdata_oe)
   );

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         errors++;
         $display("FAIL watchdog: actual %0d cycles expected under 150000", cycles);
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   // reference model state
   logic [WW-1:0] mem_m [NW];
   logic          m_s1_valid = 1'b0;
   logic [AW-1:0] m_s1_addr = '0;
   logic [3:0]    m_s1_lanes = '0;
   logic [WW-1:0] m_s1_wd = '0;
   logic          m_out_valid = 1'b0;
   logic [WW-1:0] m_out_data = '0;
   logic          m_active = 1'b0;
   logic [AW-1:0] m_base = '0;
   logic [1:0]    m_cnt = '0;

   function automatic logic [1:0] boff(logic [1:0] b, logic [1:0] s, logic lin);
      return lin ? 2'(b + s) : (b ^ s);
   endfunction

   function automatic logic [WW-1:0] merge(logic [WW-1:0] old_w, logic [WW-1:0] new_w,
                                           logic [3:0] lanes);
      logic [WW-1:0] r = old_w;
      for (int i = 0; i < 4; i++) if (lanes[i]) r[i*9 +: 9] = new_w[i*9 +: 9];
      return r;
   endfunction

   task automatic chk(string tag, logic [WW-1:0] act, logic [WW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic model_edge();
      logic [3:0]    ln;
      logic [AW-1:0] a = '0;
      logic          go = 1'b0;
      logic          sel = !en_a_n && en_b && !en_c_n;
      if (!rst_n) begin
         m_s1_valid = 0; m_out_valid = 0; m_active = 0; m_cnt = 0; m_base = 0;
         return;
      end
      if (!sleep && m_s1_valid) begin
         if (m_s1_lanes != 0) begin
            mem_m[m_s1_addr] = merge(mem_m[m_s1_addr], m_s1_wd, m_s1_lanes);
            m_out_valid = 0;
         end else begin
            m_out_valid = 1;
            m_out_data  = mem_m[m_s1_addr];
         end
      end else begin
         m_out_valid = 0;
      end
      ln = !wr_all_n ? 4'hF : (!wr_byte_n ? ~lane_sel_n : 4'h0);
      if (sleep) m_active = 0;
      else if (!load_n) begin
         if (sel) begin
            m_active = 1; m_base = addr; m_cnt = 0; go = 1; a = addr;
         end else m_active = 0;
      end else if (!adv_n && m_active) begin
         m_cnt = m_cnt + 2'd1;
         go = 1;
         a = {m_base[AW-1:2], boff(m_base[1:0], m_cnt, order_lin)};
      end
      m_s1_valid = go;
      if (go) begin
         m_s1_addr = a; m_s1_lanes = ln; m_s1_wd = wdata;
      end
   endtask

   task automatic check_out(string tag);
      logic exp_oe = m_out_valid && !out_en_n && !sleep;
      chk(tag, WW'(rdata_oe), WW'(exp_oe));
      if (exp_oe) chk(tag, rdata, m_out_data);
   endtask

   task automatic tick(string tag);
      @(posedge clk);
      model_edge();
      @(negedge clk);
      check_out(tag);
   endtask

   task automatic idle_ctl();
      load_n = 1; adv_n = 1; wr_all_n = 1; wr_byte_n = 1; lane_sel_n = 4'hF;
   endtask

   task automatic op_load(logic [AW-1:0] a, logic gw, logic bwe, logic [3:0] lsn,
                          logic [WW-1:0] d, string tag);
      load_n = 0; adv_n = 1; addr = a; wr_all_n = gw; wr_byte_n = bwe;
      lane_sel_n = lsn; wdata = d;
      tick(tag);
      idle_ctl();
   endtask

   task automatic op_read(logic [AW-1:0] a, string tag);
      op_load(a, 1'b1, 1'b1, 4'hF, '0, tag);
   endtask

   task automatic op_adv(logic gw, logic [WW-1:0] d, string tag);
      load_n = 1; adv_n = 0; wr_all_n = gw; wdata = d;
      tick(tag);
      idle_ctl();
   endtask

   task automatic op_wait(string tag);
      idle_ctl();
      tick(tag);
   endtask

   function automatic logic [WW-1:0] rword();
      return {$urandom(), $urandom()};
   endfunction

   initial begin
      void'($urandom(32'd4242));
      // R1: reset state
      repeat (3) tick("R1");
      rst_n = 1;
      op_wait("R1");

      // R4: fill memory with global writes, byte strobes random
      for (int i = 0; i < NW; i++) begin
         op_load(AW'(i), 1'b0, 1'($urandom()), 4'($urandom()), rword(), "R4");
      end
      for (int i = 0; i < NW; i++) op_read(AW'(i), "R2");
      op_wait("R2"); op_wait("R2");

      // R3: byte writes, then a read with byte-write off but strobes low
      op_load(6'd5, 1'b1, 1'b0, 4'b1010, rword(), "R3");
      op_load(6'd6, 1'b1, 1'b0, 4'b0111, rword(), "R3");
      op_load(6'd8, 1'b1, 1'b1, 4'b0000, rword(), "R3");
      op_read(6'd5, "R3"); op_read(6'd6, "R3"); op_read(6'd8, "R3");
      op_wait("R3"); op_wait("R3");

      // R5: every unselected enable combination
      for (int c = 0; c < 8; c++) begin
         {en_a_n, en_b, en_c_n} = 3'(c);
         if (3'(c) != 3'b010) op_load(6'd7, 1'b0, 1'b1, 4'hF, rword(), "R5");
      end
      {en_a_n, en_b, en_c_n} = 3'b010;
      op_read(6'd7, "R5"); op_wait("R5"); op_wait("R5");

      // R6: deselect right after a read
      op_read(6'd1, "R6");
      en_a_n = 1;
      op_read(6'd2, "R6");
      en_a_n = 0;
      op_wait("R6"); op_wait("R6");

      // R7: asynchronous output enable
      op_read(6'd10, "R7");
      op_wait("R7");
      out_en_n = 1; #1; chk("R7", WW'(rdata_oe), WW'(0));
      out_en_n = 0; #1; chk("R7", WW'(rdata_oe), WW'(1));
      chk("R7", rdata, mem_m[10]);
      op_wait("R7");

      // R8: sleep blocks writes and drive, keeps contents
      op_read(6'd9, "R8");
      op_wait("R8");
      sleep = 1; #1; chk("R8", WW'(rdata_oe), WW'(0));
      op_load(6'd9, 1'b0, 1'b1, 4'hF, rword(), "R8");
      op_read(6'd9, "R8");
      op_wait("R8");
      sleep = 0;
      op_read(6'd9, "R8"); op_wait("R8"); op_wait("R8");

      // R9: linear burst from base 14
      order_lin = 1;
      op_read(6'd14, "R9");
      repeat (3) op_adv(1'b1, '0, "R9");
      op_wait("R9"); op_wait("R9");
      op_load(6'd33, 1'b0, 1'b1, 4'hF, rword(), "R9");
      repeat (3) op_adv(1'b0, rword(), "R9");
      for (int i = 32; i < 36; i++) op_read(AW'(i), "R9");
      op_wait("R9"); op_wait("R9");

      // R10 and R11: interleaved burst from base 21 with a wait in the middle
      order_lin = 0;
      op_read(6'd21, "R10");
      op_adv(1'b1, '0, "R10");
      op_wait("R11"); op_wait("R11");
      op_adv(1'b1, '0, "R11");
      op_adv(1'b1, '0, "R10");
      op_wait("R10"); op_wait("R10");

      // R12: advance without an active burst
      en_b = 0;
      op_read(6'd3, "R12");
      en_b = 1;
      op_adv(1'b0, rword(), "R12");
      op_adv(1'b1, '0, "R12");
      op_wait("R12"); op_wait("R12");
      op_read(6'd3, "R12"); op_read(6'd4, "R12"); op_read(6'd2, "R12");
      op_wait("R12"); op_wait("R12");

      // random mix across all functions (R2 read path as primary tag)
      for (int n = 0; n < 4000; n++) begin
         load_n     = 1'($urandom_range(0, 1));
         adv_n      = 1'($urandom_range(0, 1));
         addr       = AW'($urandom());
         order_lin  = 1'($urandom());
         {en_a_n, en_b, en_c_n} = ($urandom_range(0, 99) < 85) ? 3'b010 : 3'($urandom());
         wr_all_n   = ($urandom_range(0, 99) < 80);
         wr_byte_n  = 1'($urandom());
         lane_sel_n = 4'($urandom());
         wdata      = rword();
         out_en_n   = ($urandom_range(0, 99) < 10);
         sleep      = ($urandom_range(0, 99) < 3);
         tick("R2");
      end
      sleep = 0; out_en_n = 0;
      idle_ctl();
      op_wait("R2"); op_wait("R2");

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule